// File: doc/BRIEF.md
# Priority Pin Crossbar for a Sixteen-Pin GPIO Port

This block sits between a set of internal peripheral signals and a sixteen-pin general-purpose port built from two eight-pin ports. Software turns peripheral functions on through a small register file. A fixed-priority allocator then gives each signal of every enabled function the next free pin. A pin is free when it is digital and its skip bit is clear. A pin that receives no signal stays a plain GPIO pin, driven from its output latch.

Each pin has three settings. It can be analog or digital. A digital pin drives either push-pull or open-drain. One global bit disables all weak pull-ups. Each port also has a mask and match pair, which raises a flag whenever an enabled pin differs from its expected level.

The pin assignment is a combinational function of the register contents. After a register write, the new mapping appears in the cycle that follows the write edge. If the enabled signals outnumber the free pins, the extra signals get no pin and a sticky overflow status bit is set.

Top module: `pin_xbar`

## Requirements
- R1: After reset every register reads 0. The crossbar is then off, so every `pad_oe_o` bit is 0, every pin is digital and every pull-up is on.
- R2: Signals are indexed 0 to 14 in this priority order: UART 0-1, SPI 2-5, comparator 6, clock output 7, PCA 8-10, LIN 11-12, timer0 13, timer1 14. The function-enable register (address 1) holds these functions in bits 0 to 7 in the same order. Each signal of an enabled function takes the next eligible pin in ascending order from pin 0 (port 0 bit 0) to pin 15 (port 1 bit 7).
- R3: A pin whose skip bit is set is never assigned, and it drives its output latch value. The skip registers are at address 2 (port 0) and address 9 (port 1).
- R4: A pin marked analog has the following behaviour. It is never assigned. Its output enable and output value are 0. Its pull-up is off. Its digital input reads as 0 in the pin-state register and on any routed peripheral input. The analog registers are at addresses 3 and 10, where 1 means analog.
- R5: The drive-mode registers are at addresses 4 and 11, where 1 means push-pull. A digital pin that wants to drive asserts its output enable in either of two cases: it is push-pull, or its output value is 0.
- R6: Control register bit 1 set forces every `pad_pullup_o` bit to 0. While it is clear, `pad_pullup_o` is 1 on every digital pin.
- R7: `port_match_o[q]` is 1 when any pin of port q with its mask bit set differs in digital input from its match bit. The mask registers are at addresses 5 and 12; the match registers are at addresses 6 and 13.
- R8: A clock edge at which an enabled signal lacks a pin sets control bit 7. The bit holds until a write to address 0 with data bit 7 set clears it, and such a clear takes priority over a set at the same edge.
- R9: Control bit 0 clear turns the crossbar off. No signal is assigned, every output enable is 0 and every peripheral input is 0.
- R10: An assigned pin takes its output value and drive request from its signal, and it returns its digital input to that signal. An unassigned digital pin drives its latch value; the latches are at addresses 7 and 14. An unassigned signal reads 0.
- R11: Every writable register reads back its value. Addresses 8 and 15 return the digital input of port 0 and port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| periph_out_i | input | 15 | Peripheral output value per signal |
| periph_oe_i | input | 15 | Peripheral drive request per signal |
| periph_in_o | output | 15 | Pin state returned to each signal |
| pad_in_i | input | 16 | Pad input level |
| pad_out_o | output | 16 | Pad output value |
| pad_oe_o | output | 16 | Pad output enable |
| pad_pullup_o | output | 16 | Weak pull-up enable |
| pad_analog_o | output | 16 | Pad analog mode |
| port_match_o | output | 2 | Per-port mismatch flag |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- Skipped and analog pins in the middle of an assignment run: an allocator that counted them would shift every later signal by one pin.
- Enabled signals exceeding the free pins: a wrong overflow bit would either fail to set, or drop when the condition goes away.
- A clear write while overflow holds: a set-first ordering would leave the bit stuck.
- Open-drain pins driving a 1: a design that ignored the drive mode would fight the external pull-up.
- A disabled crossbar with functions still enabled: a leaky design would drive pads or return pad levels to peripherals.

Random configurations with sparse skip and analog masks are compared with a greedy reference model.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NFUNC = 8;
  // signal count per function, highest priority first
  localparam int FUNC_W [NFUNC] = '{2, 4, 1, 1, 3, 2, 1, 1};
  localparam int PORT_BASE = 2;
  localparam int REGS_PER_PORT = 7;
  localparam int OFF_SKIP  = 0;
  localparam int OFF_ANA   = 1;
  localparam int OFF_PP    = 2;
  localparam int OFF_MASK  = 3;
  localparam int OFF_MATCH = 4;
  localparam int OFF_LATCH = 5;
  localparam int OFF_PIN   = 6;

  function automatic int total_sigs();
    int acc = 0;
    for (int f = 0; f < NFUNC; f++) acc += FUNC_W[f];
    return acc;
  endfunction

  function automatic int sig_func(int s);
    int acc = 0;
    for (int f = 0; f < NFUNC; f++) begin
      acc += FUNC_W[f];
      if (s < acc) return f;
    end
    return NFUNC - 1;
  endfunction
endpackage

// File: rtl/pin_xbar_regs.sv
module pin_xbar_regs
  import pin_xbar_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORT  = 2,
  parameter int ADDR_W = 4,
  localparam int NPIN  = NPORT * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [NPIN-1:0]   din_i,
  input  logic              short_i,
  output logic              xbar_en_o,
  output logic              pullup_off_o,
  output logic              ovf_o,
  output logic [NFUNC-1:0]  func_en_o,
  output logic [NPIN-1:0]   skip_o,
  output logic [NPIN-1:0]   analog_o,
  output logic [NPIN-1:0]   pp_o,
  output logic [NPIN-1:0]   mask_o,
  output logic [NPIN-1:0]   match_o,
  output logic [NPIN-1:0]   latch_o
);
  function automatic logic [ADDR_W-1:0] port_addr(int p, int k);
    return ADDR_W'(PORT_BASE + REGS_PER_PORT * p + k);
  endfunction

  logic              xbar_en_q, pu_off_q, ovf_q;
  logic [NFUNC-1:0]  func_q;
  logic [PORT_W-1:0] skip_q [NPORT];
  logic [PORT_W-1:0] ana_q  [NPORT];
  logic [PORT_W-1:0] pp_q   [NPORT];
  logic [PORT_W-1:0] mask_q [NPORT];
  logic [PORT_W-1:0] mtch_q [NPORT];
  logic [PORT_W-1:0] lat_q  [NPORT];
  logic              ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xbar_en_q <= 1'b0;
      pu_off_q  <= 1'b0;
      func_q    <= '0;
      for (int p = 0; p < NPORT; p++) begin
        skip_q[p] <= '0;
        ana_q[p]  <= '0;
        pp_q[p]   <= '0;
        mask_q[p] <= '0;
        mtch_q[p] <= '0;
        lat_q[p]  <= '0;
      end
    end else if (wr_en_i) begin
      if (ctrl_wr) begin
        xbar_en_q <= wdata_i[0];
        pu_off_q  <= wdata_i[1];
      end
      if (addr_i == ADDR_W'(1)) func_q <= wdata_i[NFUNC-1:0];
      for (int p = 0; p < NPORT; p++) begin
        if (addr_i == port_addr(p, OFF_SKIP))  skip_q[p] <= wdata_i;
        if (addr_i == port_addr(p, OFF_ANA))   ana_q[p]  <= wdata_i;
        if (addr_i == port_addr(p, OFF_PP))    pp_q[p]   <= wdata_i;
        if (addr_i == port_addr(p, OFF_MASK))  mask_q[p] <= wdata_i;
        if (addr_i == port_addr(p, OFF_MATCH)) mtch_q[p] <= wdata_i;
        if (addr_i == port_addr(p, OFF_LATCH)) lat_q[p]  <= wdata_i;
      end
    end
  end

  // clear wins over a simultaneous set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovf_q <= 1'b0;
    else if (ctrl_wr && wdata_i[PORT_W-1]) ovf_q <= 1'b0;
    else if (short_i)                     ovf_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(0)) begin
      rdata_o[0]        = xbar_en_q;
      rdata_o[1]        = pu_off_q;
      rdata_o[PORT_W-1] = ovf_q;
    end
    if (addr_i == ADDR_W'(1)) rdata_o[NFUNC-1:0] = func_q;
    for (int p = 0; p < NPORT; p++) begin
      if (addr_i == port_addr(p, OFF_SKIP))  rdata_o = skip_q[p];
      if (addr_i == port_addr(p, OFF_ANA))   rdata_o = ana_q[p];
      if (addr_i == port_addr(p, OFF_PP))    rdata_o = pp_q[p];
      if (addr_i == port_addr(p, OFF_MASK))  rdata_o = mask_q[p];
      if (addr_i == port_addr(p, OFF_MATCH)) rdata_o = mtch_q[p];
      if (addr_i == port_addr(p, OFF_LATCH)) rdata_o = lat_q[p];
      if (addr_i == port_addr(p, OFF_PIN))   rdata_o = din_i[p*PORT_W +: PORT_W];
    end
  end

  assign xbar_en_o    = xbar_en_q;
  assign pullup_off_o = pu_off_q;
  assign ovf_o        = ovf_q;
  assign func_en_o    = func_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_flat
    assign skip_o  [p*PORT_W +: PORT_W] = skip_q[p];
    assign analog_o[p*PORT_W +: PORT_W] = ana_q[p];
    assign pp_o    [p*PORT_W +: PORT_W] = pp_q[p];
    assign mask_o  [p*PORT_W +: PORT_W] = mask_q[p];
    assign match_o [p*PORT_W +: PORT_W] = mtch_q[p];
    assign latch_o [p*PORT_W +: PORT_W] = lat_q[p];
  end
endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc #(
  parameter int NPIN   = 16,
  parameter int NSIG   = 15,
  parameter int PIN_IW = 4,
  parameter int SIG_IW = 4
) (
  input  logic [NPIN-1:0]   elig_i,
  input  logic [NSIG-1:0]   req_i,
  output logic [NPIN-1:0]   pin_hit_o,
  output logic [SIG_IW-1:0] pin_sig_o [NPIN],
  output logic [NSIG-1:0]   sig_hit_o,
  output logic [PIN_IW-1:0] sig_pin_o [NSIG],
  output logic              short_o
);
  int pin_rank [NPIN];
  int sig_rank [NSIG];
  int cnt_p, cnt_s;

  // k-th requested signal pairs with k-th eligible pin
  always_comb begin
    cnt_p = 0;
    for (int p = 0; p < NPIN; p++) begin
      pin_rank[p] = cnt_p;
      if (elig_i[p]) cnt_p = cnt_p + 1;
    end
    cnt_s = 0;
    for (int s = 0; s < NSIG; s++) begin
      sig_rank[s] = cnt_s;
      if (req_i[s]) cnt_s = cnt_s + 1;
    end
  end

  always_comb begin
    pin_hit_o = '0;
    sig_hit_o = '0;
    for (int p = 0; p < NPIN; p++) pin_sig_o[p] = '0;
    for (int s = 0; s < NSIG; s++) sig_pin_o[s] = '0;
    for (int p = 0; p < NPIN; p++) begin
      for (int s = 0; s < NSIG; s++) begin
        if (elig_i[p] && req_i[s] && pin_rank[p] == sig_rank[s]) begin
          pin_hit_o[p] = 1'b1;
          pin_sig_o[p] = SIG_IW'(s);
          sig_hit_o[s] = 1'b1;
          sig_pin_o[s] = PIN_IW'(p);
        end
      end
    end
  end

  assign short_o = |(req_i & ~sig_hit_o);
endmodule

// File: rtl/pin_xbar_pad.sv
module pin_xbar_pad (
  input  logic analog_i,
  input  logic pp_i,
  input  logic latch_i,
  input  logic sel_i,
  input  logic p_out_i,
  input  logic p_oe_i,
  input  logic pullup_off_i,
  input  logic xbar_en_i,
  input  logic pad_in_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic pad_pu_o,
  output logic din_o
);
  logic val, want;

  assign val       = sel_i ? p_out_i : latch_i;
  assign want      = sel_i ? p_oe_i : 1'b1;
  assign pad_out_o = ~analog_i & val;
  // open-drain releases the pad for a 1
  assign pad_oe_o  = xbar_en_i & ~analog_i & want & (pp_i | ~val);
  assign pad_pu_o  = ~pullup_off_i & ~analog_i;
  assign din_o     = ~analog_i & pad_in_i;
endmodule

// File: rtl/pin_xbar_match.sv
module pin_xbar_match #(
  parameter int PORT_W = 8
) (
  input  logic [PORT_W-1:0] din_i,
  input  logic [PORT_W-1:0] mask_i,
  input  logic [PORT_W-1:0] match_i,
  output logic              hit_o
);
  assign hit_o = |((din_i ^ match_i) & mask_i);
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int NPORT   = 2,
  localparam int NPIN   = NPORT * PORT_W,
  localparam int NSIG   = total_sigs(),
  localparam int ADDR_W = $clog2(PORT_BASE + REGS_PER_PORT * NPORT),
  localparam int PIN_IW = $clog2(NPIN),
  localparam int SIG_IW = $clog2(NSIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [NSIG-1:0]   periph_out_i,
  input  logic [NSIG-1:0]   periph_oe_i,
  output logic [NSIG-1:0]   periph_in_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pad_pullup_o,
  output logic [NPIN-1:0]   pad_analog_o,
  output logic [NPORT-1:0]  port_match_o
);
  logic              xbar_en, pullup_off, ovf, short;
  logic [NFUNC-1:0]  func_en;
  logic [NPIN-1:0]   skip_v, analog_v, pp_v, mask_v, match_v, latch_v, din;
  logic [NPIN-1:0]   pin_hit;
  logic [SIG_IW-1:0] pin_sig [NPIN];
  logic [NSIG-1:0]   sig_hit, req;
  logic [PIN_IW-1:0] sig_pin [NSIG];

  pin_xbar_regs #(.PORT_W(PORT_W), .NPORT(NPORT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .din_i(din), .short_i(short),
    .xbar_en_o(xbar_en), .pullup_off_o(pullup_off), .ovf_o(ovf),
    .func_en_o(func_en), .skip_o(skip_v), .analog_o(analog_v), .pp_o(pp_v),
    .mask_o(mask_v), .match_o(match_v), .latch_o(latch_v)
  );

  for (genvar s = 0; s < NSIG; s++) begin : g_req
    localparam int F = sig_func(s);
    assign req[s]         = xbar_en & func_en[F];
    assign periph_in_o[s] = sig_hit[s] & din[sig_pin[s]];
  end

  pin_xbar_alloc #(.NPIN(NPIN), .NSIG(NSIG), .PIN_IW(PIN_IW), .SIG_IW(SIG_IW)) u_alloc (
    .elig_i(~skip_v & ~analog_v), .req_i(req),
    .pin_hit_o(pin_hit), .pin_sig_o(pin_sig),
    .sig_hit_o(sig_hit), .sig_pin_o(sig_pin), .short_o(short)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pad
    pin_xbar_pad u_pad (
      .analog_i(analog_v[p]), .pp_i(pp_v[p]), .latch_i(latch_v[p]),
      .sel_i(pin_hit[p]), .p_out_i(periph_out_i[pin_sig[p]]),
      .p_oe_i(periph_oe_i[pin_sig[p]]), .pullup_off_i(pullup_off),
      .xbar_en_i(xbar_en), .pad_in_i(pad_in_i[p]),
      .pad_out_o(pad_out_o[p]), .pad_oe_o(pad_oe_o[p]),
      .pad_pu_o(pad_pullup_o[p]), .din_o(din[p])
    );
  end

  assign pad_analog_o = analog_v;

  for (genvar q = 0; q < NPORT; q++) begin : g_match
    pin_xbar_match #(.PORT_W(PORT_W)) u_match (
      .din_i(din[q*PORT_W +: PORT_W]), .mask_i(mask_v[q*PORT_W +: PORT_W]),
      .match_i(match_v[q*PORT_W +: PORT_W]), .hit_o(port_match_o[q])
    );
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk #(
  parameter int NPIN   = 16,
  parameter int NSIG   = 15,
  parameter int ADDR_W = 4,
  parameter int PORT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PORT_W-1:0] wdata_i,
  input logic              xbar_en,
  input logic              pullup_off,
  input logic              ovf,
  input logic [NPIN-1:0]   analog_v,
  input logic [NPIN-1:0]   pp_v,
  input logic [NPIN-1:0]   skip_v,
  input logic [NPIN-1:0]   latch_v,
  input logic [NPIN-1:0]   pad_out_o,
  input logic [NPIN-1:0]   pad_oe_o,
  input logic [NPIN-1:0]   pad_pullup_o,
  input logic [NSIG-1:0]   periph_in_o
);
  logic clr;
  assign clr = wr_en_i && (addr_i == ADDR_W'(0)) && wdata_i[PORT_W-1];

  assert_gate_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xbar_en |-> (pad_oe_o == '0 && periph_in_o == '0));

  assert_od_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~pp_v & pad_out_o) == '0);

  assert_analog_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_out_o | pad_pullup_o) & analog_v) == '0);

  assert_pullup_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pullup_off |-> pad_pullup_o == '0);

  assert_skip_gpio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ latch_v) & skip_v & ~analog_v) == '0);

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !clr) |=> ovf);
endmodule

bind pin_xbar pin_xbar_chk #(.NPIN(NPIN), .NSIG(NSIG), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .xbar_en(xbar_en), .pullup_off(pullup_off), .ovf(ovf),
  .analog_v(analog_v), .pp_v(pp_v), .skip_v(skip_v), .latch_v(latch_v),
  .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .pad_pullup_o(pad_pullup_o),
  .periph_in_o(periph_in_o)
);

// File: tb/pin_xbar_test.sv
module pin_xbar_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [14:0] p_out = '0, p_oe = '0, p_in;
  logic [15:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_an;
  logic [1:0]  pmatch;

  int checks = 0;
  int errors = 0;

  // mirror of the register file
  logic       m_xen = 0, m_puoff = 0, m_ovf = 0;
  logic [7:0] m_func = '0;
  logic [7:0] m_skip [2] = '{default: '0};
  logic [7:0] m_an   [2] = '{default: '0};
  logic [7:0] m_pp   [2] = '{default: '0};
  logic [7:0] m_mask [2] = '{default: '0};
  logic [7:0] m_mat  [2] = '{default: '0};
  logic [7:0] m_lat  [2] = '{default: '0};

  logic [15:0] e_out, e_oe, e_pu, e_an, e_din;
  logic [14:0] e_pin;
  logic [1:0]  e_match;
  logic        e_short;

  localparam int FW [8] = '{2, 4, 1, 1, 3, 2, 1, 1};

  always #2 clk = ~clk;

  pin_xbar uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .periph_out_i(p_out), .periph_oe_i(p_oe), .periph_in_o(p_in),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pullup_o(pad_pu),
    .pad_analog_o(pad_an), .port_match_o(pmatch)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_eval();
    logic [15:0] sk, an, pp, lat;
    int sel [16];
    int spin [15];
    int s, ptr;
    logic v, drv;
    sk  = {m_skip[1], m_skip[0]};
    an  = {m_an[1], m_an[0]};
    pp  = {m_pp[1], m_pp[0]};
    lat = {m_lat[1], m_lat[0]};
    for (int p = 0; p < 16; p++) sel[p] = -1;
    for (int k = 0; k < 15; k++) spin[k] = -1;
    s = 0; ptr = 0; e_short = 0;
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < FW[f]; k++) begin
        if (m_xen && m_func[f]) begin
          while (ptr < 16 && (sk[ptr] || an[ptr])) ptr++;
          if (ptr < 16) begin sel[ptr] = s; spin[s] = ptr; ptr++; end
          else e_short = 1;
        end
        s++;
      end
    end
    e_din = pad_in & ~an;
    for (int p = 0; p < 16; p++) begin
      v   = (sel[p] >= 0) ? p_out[sel[p]] : lat[p];
      drv = (sel[p] >= 0) ? p_oe[sel[p]] : 1'b1;
      e_out[p] = !an[p] && v;
      e_oe[p]  = m_xen && !an[p] && drv && (pp[p] || !v);
      e_pu[p]  = !m_puoff && !an[p];
    end
    e_an = an;
    for (int k = 0; k < 15; k++) e_pin[k] = (spin[k] >= 0) ? e_din[spin[k]] : 1'b0;
    for (int q = 0; q < 2; q++)
      e_match[q] = |((e_din[q*8 +: 8] ^ m_mat[q]) & m_mask[q]);
  endtask

  task automatic wr(int a, logic [7:0] d);
    int p, k;
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 0) begin
      m_xen = d[0]; m_puoff = d[1];
      if (d[7]) m_ovf = 0;
    end else if (a == 1) m_func = d;
    else if (a >= 2 && a < 16) begin
      p = (a - 2) / 7; k = (a - 2) % 7;
      case (k)
        0: m_skip[p] = d;
        1: m_an[p]   = d;
        2: m_pp[p]   = d;
        3: m_mask[p] = d;
        4: m_mat[p]  = d;
        5: m_lat[p]  = d;
        default: ;
      endcase
    end
    model_eval();
    if (e_short) m_ovf = 1;
  endtask

  task automatic rd_chk(int a, logic [7:0] exp, string tag);
    addr = 4'(a);
    #0.2;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic compare_all(string tag);
    @(negedge clk);
    #0.5;
    model_eval();
    chk({tag, " pad_out"}, 32'(pad_out), 32'(e_out));
    chk({tag, " pad_oe"}, 32'(pad_oe), 32'(e_oe));
    chk({tag, " pullup"}, 32'(pad_pu), 32'(e_pu));
    chk({tag, " analog"}, 32'(pad_an), 32'(e_an));
    chk({tag, " periph_in"}, 32'(p_in), 32'(e_pin));
    chk({tag, " match"}, 32'(pmatch), 32'(e_match));
    rd_chk(0, {m_ovf, 5'b0, m_puoff, m_xen}, {tag, " ctrl/R8"});
    rd_chk(8, e_din[7:0], {tag, " pin0/R4"});
    rd_chk(15, e_din[15:8], {tag, " pin1/R4"});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    compare_all("R1 reset");
    chk("R1 oe", 32'(pad_oe), 32'h0);
    chk("R1 pullup", 32'(pad_pu), 32'hFFFF);
    rd_chk(1, 8'h00, "R1 func");
    rd_chk(4, 8'h00, "R1 pp0");

    // R11 read-back
    wr(5, 8'h3C);
    wr(12, 8'h5A);
    rd_chk(5, 8'h3C, "R11 mask0");
    rd_chk(12, 8'h5A, "R11 mask1");
    wr(5, 8'h00);
    wr(12, 8'h00);

    // R2 / R10 UART only, priority start at pin 0
    wr(4, 8'hFF);
    wr(11, 8'hFF);
    wr(14, 8'hC3);
    wr(1, 8'h01);
    wr(0, 8'h01);
    p_out = 15'h5555; p_oe = 15'h7FFF; pad_in = 16'h0001;
    compare_all("R2 uart");
    chk("R2 uart pins", 32'(pad_out[1:0]), 32'h1);
    chk("R10 latch port1", 32'(pad_out[15:8]), 32'hC3);
    chk("R10 rx route", 32'(p_in[1:0]), 32'h1);

    // R2 all functions: 15 pins, no overflow
    p_out = 15'h7FFF;
    wr(1, 8'hFF);
    compare_all("R2 all");
    chk("R2 last pin latch", 32'(pad_out[15]), 32'h1);

    // R3 skip pins 0 and 2 -> overflow (R8)
    wr(2, 8'h05);
    compare_all("R3 skip");
    chk("R3 skip pins", 32'(pad_out[2:0]), 32'h2);
    rd_chk(0, 8'h81, "R8 set");

    // R8 sticky after condition removed, then clear
    wr(2, 8'h00);
    compare_all("R8 sticky");
    rd_chk(0, 8'h81, "R8 hold");
    wr(0, 8'h81);
    compare_all("R8 clear");
    rd_chk(0, 8'h01, "R8 cleared");

    // R4 analog pin 1
    wr(3, 8'h02);
    pad_in = 16'hFFFF;
    compare_all("R4 analog");
    chk("R4 oe", 32'(pad_oe[1]), 32'h0);
    chk("R4 periph", 32'(p_in[1:0]), 32'h3);
    rd_chk(8, 8'hFD, "R4 pin read");
    wr(3, 8'h00);

    // R5 open-drain
    wr(1, 8'h00);
    wr(4, 8'h0F);
    wr(7, 8'h33);
    compare_all("R5 drive");
    chk("R5 oe", 32'(pad_oe[7:0]), 32'hCF);

    // R6 pull-ups off
    wr(0, 8'h03);
    compare_all("R6 pullup");
    chk("R6 off", 32'(pad_pu), 32'h0);
    wr(0, 8'h01);

    // R7 mask/match
    wr(5, 8'hFF);
    wr(6, 8'h3C);
    pad_in = 16'h003C;
    compare_all("R7 equal");
    chk("R7 no flag", 32'(pmatch[0]), 32'h0);
    pad_in = 16'h003D;
    compare_all("R7 differ");
    chk("R7 flag", 32'(pmatch[0]), 32'h1);
    wr(5, 8'hFE);
    compare_all("R7 masked");
    chk("R7 masked", 32'(pmatch[0]), 32'h0);

    // R9 crossbar off with functions enabled
    wr(1, 8'hFF);
    wr(0, 8'h00);
    pad_in = 16'hFFFF;
    compare_all("R9 off");
    chk("R9 oe", 32'(pad_oe), 32'h0);
    chk("R9 periph", 32'(p_in), 32'h0);

    // random configurations
    for (int it = 0; it < 300; it++) begin
      for (int n = 0; n < 4; n++) begin
        int a;
        logic [7:0] d;
        a = int'($urandom % 16);
        d = 8'($urandom);
        if (a == 2 || a == 3 || a == 9 || a == 10) d = d & 8'($urandom) & 8'($urandom);
        if (a == 0 && ($urandom % 4) != 0) d[0] = 1'b1;
        wr(a, d);
      end
      p_out  = 15'($urandom);
      p_oe   = 15'($urandom);
      pad_in = 16'($urandom);
      compare_all("R10 random");
    end

    finish_run();
  end
endmodule